// File: doc/BRIEF.md
# Three-Bit Regulator Frame CRC Unit

This block protects 32-bit regulator bus frames with a three-bit cyclic redundancy code. The code covers the 29 upper bits of a frame and is carried in bits 2:0. The generator polynomial is x^3 + x + 1. The remainder starts at zero and the data is fed most significant bit first. There is no bit reflection and no final inversion. The result is the remainder of the 29 data bits, followed by three zero bits, divided by the polynomial.

The unit offers three paths that run side by side. The generate path takes a 29-bit payload and returns the complete frame with the code appended, within the same cycle. The check path takes a received frame and flags, within the same cycle, whether its low three bits agree with the code computed over its upper bits. The serial path accepts a frame on a start strobe. It then folds in one data bit per clock and pulses done once all 29 data bits have been consumed. This suits places where the combinational XOR tree does not fit the timing budget.

Top module: `crc3_frame_unit`

## Requirements
- R1: frame_o[31:3] equals payload_i and frame_o[2:0] equals the remainder of payload_i·x^3 modulo x^3+x+1, with zero initial remainder, MSB first, no reflection and no final XOR. An all-zero payload gives code 000; payload 1 gives code 011.
- R2: rx_crc_ok_o is 1 exactly when rx_frame_i[2:0] equals the code computed over rx_frame_i[31:3]. rx_crc_err_o is always its complement.
- R3: The low three bits of a frame do not enter the computation. Across the eight values of rx_frame_i[2:0], exactly one sets rx_crc_ok_o. Two serial frames that differ only in bits 2:0 yield the same ser_crc_o.
- R4: ser_start_i sampled high while ser_busy_o is 0 captures ser_frame_i, and ser_busy_o is 1 from the next cycle on.
- R5: ser_done_o is a one-cycle pulse that rises exactly 29 clock edges after the accepting edge. ser_busy_o falls on that same edge.
- R6: When ser_done_o is 1, ser_crc_o equals the R1 code of the captured bits 31:3. ser_match_o is 1 when that code equals the captured bits 2:0. Both outputs hold until the next accepted start.
- R7: ser_start_i while ser_busy_o is 1 is ignored. The running result and the done timing belong to the first frame.
- R8: While rst_ni is low, and after it is released, ser_busy_o, ser_done_o, ser_crc_o and ser_match_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| payload_i | input | 29 | Data bits for the generate path |
| frame_o | output | 32 | Payload with code appended |
| rx_frame_i | input | 32 | Received frame for the check path |
| rx_crc_ok_o | output | 1 | Code of rx_frame_i matches |
| rx_crc_err_o | output | 1 | Code of rx_frame_i mismatches |
| ser_start_i | input | 1 | Start a serial computation |
| ser_frame_i | input | 32 | Frame captured by the serial path at start |
| ser_busy_o | output | 1 | Serial computation in progress |
| ser_done_o | output | 1 | One-cycle pulse when the serial code is ready |
| ser_crc_o | output | 3 | Serial code result |
| ser_match_o | output | 1 | Serial code equals captured bits 2:0 |

## Verification
The generate and check outputs are combinational. They are sampled one time unit after their inputs change, with no clock edge in between. The serial path is driven on falling edges, so the start is accepted at the next rising edge. Busy is sampled half a cycle after that edge. Done is checked low at the sample just before the 29th rising edge after acceptance, high at the sample just after it, and low again one cycle later. The code and match outputs are read while done is high and once more a few cycles later, to confirm they are held.

// File: rtl/crc3_pkg.sv
package crc3_pkg;
  localparam int FRAME_W = 32;
  localparam int CRC_W   = 3;
  localparam int DATA_W  = FRAME_W - CRC_W;
  localparam logic [CRC_W-1:0] POLY = 3'b011;  // x^3 + x + 1, x^3 implicit

  // One MSB-first division step on the remainder register
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] rem,
                                                input logic            din);
    logic fb;
    fb = din ^ rem[CRC_W-1];
    return {rem[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction
endpackage

// File: rtl/crc3_comb.sv
module crc3_comb
  import crc3_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CRC_W
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] crc_o
);
  always_comb begin
    logic [CW-1:0] r;
    r = '0;
    for (int i = DW - 1; i >= 0; i--) r = crc_step(r, data_i[i]);
    crc_o = r;
  end
endmodule

// File: rtl/crc3_serial.sv
module crc3_serial
  import crc3_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CRC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW+CW-1:0] frame_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] crc_o,
  output logic          match_o
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

  logic [DW-1:0]    sh_q;
  logic [CW-1:0]    rem_q, low_q, rem_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, match_q;

  assign rem_nxt = crc_step(rem_q, sh_q[DW-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      rem_q   <= '0;
      low_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      match_q <= 1'b0;
    end else if (!busy_q) begin
      done_q <= 1'b0;
      if (start_i) begin
        sh_q    <= frame_i[DW+CW-1:CW];
        low_q   <= frame_i[CW-1:0];
        rem_q   <= '0;
        cnt_q   <= '0;
        busy_q  <= 1'b1;
        match_q <= 1'b0;
      end
    end else begin
      rem_q <= rem_nxt;
      sh_q  <= {sh_q[DW-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        match_q <= (rem_nxt == low_q);
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign crc_o   = rem_q;
  assign match_o = match_q;
endmodule

// File: rtl/crc3_frame_unit.sv
module crc3_frame_unit
  import crc3_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] payload_i,
  output logic [FRAME_W-1:0] frame_o,
  input  logic [FRAME_W-1:0] rx_frame_i,
  output logic              rx_crc_ok_o,
  output logic              rx_crc_err_o,
  input  logic              ser_start_i,
  input  logic [FRAME_W-1:0] ser_frame_i,
  output logic              ser_busy_o,
  output logic              ser_done_o,
  output logic [CRC_W-1:0]  ser_crc_o,
  output logic              ser_match_o
);
  logic [CRC_W-1:0] gen_crc, chk_crc;

  crc3_comb u_gen (.data_i(payload_i), .crc_o(gen_crc));
  crc3_comb u_chk (.data_i(rx_frame_i[FRAME_W-1:CRC_W]), .crc_o(chk_crc));

  assign frame_o      = {payload_i, gen_crc};
  assign rx_crc_ok_o  = (chk_crc == rx_frame_i[CRC_W-1:0]);
  assign rx_crc_err_o = ~rx_crc_ok_o;

  crc3_serial u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ser_start_i),
    .frame_i (ser_frame_i),
    .busy_o  (ser_busy_o),
    .done_o  (ser_done_o),
    .crc_o   (ser_crc_o),
    .match_o (ser_match_o)
  );
endmodule

// File: rtl/crc3_frame_unit_chk.sv
module crc3_frame_unit_chk
  import crc3_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] payload_i,
  input logic [FRAME_W-1:0] frame_o,
  input logic [FRAME_W-1:0] rx_frame_i,
  input logic              rx_crc_ok_o,
  input logic              ser_start_i,
  input logic              ser_busy_o,
  input logic              ser_done_o,
  input logic [CRC_W-1:0]  ser_crc_o
);
  logic [5:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        win_q <= '0;
    else if (ser_start_i && !ser_busy_o) win_q <= '0;
    else if (ser_busy_o)                win_q <= win_q + 1'b1;
  end

  // R1: payload passes through to the upper frame bits
  assert_payload_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o[FRAME_W-1:CRC_W] == payload_i);

  // R2: a frame built by the generate path checks clean
  assert_gen_checks_ok_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_frame_i == frame_o) |-> rx_crc_ok_o);

  assert_start_accept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_start_i && !ser_busy_o) |=> ser_busy_o);

  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_done_o |=> !ser_done_o);

  assert_busy_ends_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ser_busy_o) |-> ser_done_o);

  assert_done_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_done_o |-> (win_q == 6'(DATA_W)));

  assert_result_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ser_busy_o && !ser_start_i) |=> $stable(ser_crc_o));
endmodule

bind crc3_frame_unit crc3_frame_unit_chk u_chk_bind (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .payload_i  (payload_i),
  .frame_o    (frame_o),
  .rx_frame_i (rx_frame_i),
  .rx_crc_ok_o(rx_crc_ok_o),
  .ser_start_i(ser_start_i),
  .ser_busy_o (ser_busy_o),
  .ser_done_o (ser_done_o),
  .ser_crc_o  (ser_crc_o)
);

// File: tb/crc3_frame_unit_tb.sv
module crc3_frame_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [28:0] payload_i = '0;
  logic [31:0] frame_o;
  logic [31:0] rx_frame_i = '0;
  logic        rx_crc_ok_o, rx_crc_err_o;
  logic        ser_start_i = 1'b0;
  logic [31:0] ser_frame_i = '0;
  logic        ser_busy_o, ser_done_o, ser_match_o;
  logic [2:0]  ser_crc_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  crc3_frame_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .payload_i(payload_i), .frame_o(frame_o),
    .rx_frame_i(rx_frame_i), .rx_crc_ok_o(rx_crc_ok_o), .rx_crc_err_o(rx_crc_err_o),
    .ser_start_i(ser_start_i), .ser_frame_i(ser_frame_i), .ser_busy_o(ser_busy_o),
    .ser_done_o(ser_done_o), .ser_crc_o(ser_crc_o), .ser_match_o(ser_match_o)
  );

  localparam logic [31:0] VEC [12] = '{
    32'h7007_FFF8, 32'h7087_FFF8, 32'h777F_FFF8, 32'hFFFF_FFFF,
    32'h0000_0000, 32'h0000_0008, 32'h8000_0000, 32'hA5A5_A5A5,
    32'h1234_5678, 32'hFFFF_FFF8, 32'h5A5A_5A5F, 32'h0000_000F
  };

  // Reference: long division of the masked word by 1011b
  function automatic logic [2:0] model_crc(input logic [31:0] w);
    logic [31:0] r;
    logic [31:0] d;
    r = w & 32'hFFFF_FFF8;
    d = 32'hB000_0000;
    for (int i = 31; i >= 3; i--) begin
      if (r[i]) r = r ^ d;
      d = d >> 1;
    end
    return r[2:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Runs one serial computation; a second start mid-run when intrude is set
  task automatic run_serial(input string req, input logic [31:0] w,
                            input bit intrude, input logic [31:0] w2);
    logic [2:0] ec;
    ec = model_crc(w);
    @(negedge clk_i);
    ser_frame_i = w;
    ser_start_i = 1'b1;
    @(negedge clk_i);
    ser_start_i = 1'b0;
    ser_frame_i = ~w;
    check({req, " busy after start R4"}, 32'(ser_busy_o), 32'd1);
    for (int k = 0; k < 28; k++) begin
      @(negedge clk_i);
      if (intrude && k == 10) begin
        ser_frame_i = w2;
        ser_start_i = 1'b1;
      end else begin
        ser_start_i = 1'b0;
      end
    end
    check({req, " done not early R5"}, 32'(ser_done_o), 32'd0);
    @(negedge clk_i);
    check({req, " done at 29 R5"}, 32'(ser_done_o), 32'd1);
    check({req, " busy dropped R5"}, 32'(ser_busy_o), 32'd0);
    check({req, " crc R6"}, 32'(ser_crc_o), 32'(ec));
    check({req, " match R6"}, 32'(ser_match_o), 32'(ec == w[2:0]));
    @(negedge clk_i);
    check({req, " done one cycle R5"}, 32'(ser_done_o), 32'd0);
    repeat (3) @(negedge clk_i);
    check({req, " crc held R6"}, 32'(ser_crc_o), 32'(ec));
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R8: reset state, during and after reset
    #15;
    check("R8 busy in reset", 32'(ser_busy_o), 32'd0);
    check("R8 done in reset", 32'(ser_done_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8 crc after reset", 32'(ser_crc_o), 32'd0);
    check("R8 match after reset", 32'(ser_match_o), 32'd0);

    // R1/R2: table walk through generate and check paths
    foreach (VEC[i]) begin
      payload_i  = VEC[i][31:3];
      rx_frame_i = VEC[i];
      #1;
      check("R1 frame", frame_o, {VEC[i][31:3], model_crc(VEC[i])});
      check("R2 ok", 32'(rx_crc_ok_o), 32'(model_crc(VEC[i]) == VEC[i][2:0]));
      check("R2 err", 32'(rx_crc_err_o), 32'(model_crc(VEC[i]) != VEC[i][2:0]));
    end

    // R1: hand-known corner codes
    payload_i = '0;
    #1 check("R1 zero payload", 32'(frame_o[2:0]), 32'd0);
    payload_i = 29'd1;
    #1 check("R1 payload one", 32'(frame_o[2:0]), 32'd3);

    // R3: exactly one low-bit value checks ok
    for (int s = 0; s < 3; s++) begin
      int hits;
      hits = 0;
      for (int c = 0; c < 8; c++) begin
        rx_frame_i = {VEC[s][31:3], 3'(c)};
        #1;
        if (rx_crc_ok_o) hits++;
      end
      check("R3 single valid code", 32'(hits), 32'd1);
    end

    // R4/R5/R6: serial path, all-ones payload and command-frame pattern
    run_serial("all-ones", 32'hFFFF_FFF8, 1'b0, '0);
    run_serial("cmd frame", {VEC[0][31:3], model_crc(VEC[0])}, 1'b0, '0);
    run_serial("mixed", VEC[8], 1'b0, '0);
    // R3: low bits differ only, serial code identical
    run_serial("R3 low bits a", 32'h7007_FFF8, 1'b0, '0);
    run_serial("R3 low bits b", 32'h7007_FFFD, 1'b0, '0);
    // R7: start while busy is ignored
    run_serial("R7 intrude", VEC[2], 1'b1, VEC[7]);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule